// File: doc/BRIEF.md
# Preemptive Four-Channel Request Arbiter

This block chooses which of four request channels a transfer engine serves next. Each channel has a byte-wide setup register. The register holds a 2-bit priority level and two preemption permissions. The block registers the raw request lines once, makes that copy readable as status, and keeps at most one channel granted at a time. The grant is chosen by one of two policies:

- **Fixed mode:** the highest numeric level among the requesters wins.
- **Rotating mode:** the first requester after the last granted channel wins.

In fixed mode, a waiting request may take over the grant from the channel now being served. This needs two conditions at once. The served channel must be marked suspendable, and the requester must not be barred from preempting. The suspended channel keeps its request line up and returns to the grant once no stronger request is left.

Setup registers are written and read through a plain byte port. The grant, preempt and error outputs are plain level and pulse signals. There is no valid/ready handshake and no back-pressure. The engine reports the end of a service on `chan_done`.

Setup contents are undefined after reset, so all four bytes must be written before requests are raised. In fixed mode, two channels with the same level form an illegal setup. The block reports this on `cfg_err` and withholds every grant until the setup is fixed or rotating mode is chosen.

Top module: `dma_chan_arb`

## Requirements
- R1: Setup byte address a selects channel 3-a (address 0 is channel 3, address 3 is channel 0). In each byte, bit 7 is the suspendable flag, bit 6 is the preempt-barred flag, and bits 1:0 are the level. Read data shows these fields for the addressed channel, and bits 5:2 always read 0.
- R2: `req_status[n]` reads 1 one cycle after `req_in[n]` is high, and reads 0 one cycle after it is low.
- R3: In fixed mode with no grant active, the block grants the requesting channel with the largest level, where 3 beats 2 beats 1 beats 0. The grant appears two cycles after the request is raised.
- R4: In fixed mode, two equal levels raise `cfg_err` as soon as the setup holds them. While `cfg_err` is 1, no grant is held: `grant_valid` falls one cycle after the error appears and stays 0.
- R5: An active channel whose suspendable flag is 0 is never taken off the grant by another request.
- R6: A requester whose preempt-barred flag is 1 never takes the grant from an active channel, whatever its level.
- R7: If the active channel is suspendable and a requester has a higher level and is not barred, `preempt` pulses for one cycle. The grant moves to that requester in the same cycle, two cycles after its request is raised.
- R8: A suspended channel that keeps requesting is granted again after the preemptor finishes, provided no higher-level request remains.
- R9: In rotating mode, levels and preemption flags are ignored, and `preempt` never pulses. Each new grant goes to the first requester after the last granted channel, in increasing channel order with wrap-around.
- R10: In rotating mode `cfg_err` is 0 even when levels repeat.
- R11: At most one grant is active at a time. `grant_ch` changes only when the active channel reports done or when a preemption happens. After `chan_done`, `grant_valid` is 0 for one cycle before the next grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the setup byte |
| cfg_addr | input | 2 | Setup byte address (reverse channel order) |
| cfg_wdata | input | 8 | Setup byte write data |
| cfg_rdata | output | 8 | Setup byte read data for `cfg_addr` |
| rr_mode | input | 1 | 1 selects rotating grants, 0 selects fixed levels |
| req_in | input | 4 | Per-channel service request lines |
| chan_done | input | 1 | Active channel has finished its service |
| grant_valid | output | 1 | A channel is granted |
| grant_ch | output | 2 | Index of the granted channel |
| preempt | output | 1 | One-cycle pulse when a grant is taken over |
| cfg_err | output | 1 | Repeated level found in fixed mode |
| req_status | output | 4 | Registered copy of the request lines |

## Verification
The assertions assume that `chan_done` is raised only while a grant is active. The error-blocking and preemption properties also assume the setup bytes do not change in the same cycle as a grant decision. The stimulus meets both assumptions: it writes setup bytes only while the requests involved are stable, and it pulses `chan_done` for exactly one cycle while a channel is granted. When a channel finishes in fixed mode, the stimulus drops that channel's request together with `chan_done`. In rotating mode it keeps all four requests up so that the wrap-around order is visible.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int REG_W    = 8;
  localparam int LVL_W    = 2;
  localparam int SUSP_BIT = 7;
  localparam int NOPE_BIT = 6;
  localparam int PAD_W    = REG_W - 2 - LVL_W;

  typedef struct packed {
    logic             susp_ok;
    logic             no_pre;
    logic [LVL_W-1:0] level;
  } chan_cfg_t;

  function automatic chan_cfg_t unpack_byte(input logic [REG_W-1:0] b);
    chan_cfg_t c;
    c.susp_ok = b[SUSP_BIT];
    c.no_pre  = b[NOPE_BIT];
    c.level   = b[LVL_W-1:0];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] pack_byte(input chan_cfg_t c);
    return {c.susp_ok, c.no_pre, {PAD_W{1'b0}}, c.level};
  endfunction
endpackage

// File: rtl/dma_arb_regs.sv
module dma_arb_regs
  import dma_arb_pkg::*;
#(
  parameter int NCH = 4,
  localparam int AW = $clog2(NCH)
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic [AW-1:0]         addr,
  input  logic [REG_W-1:0]      wdata,
  output logic [REG_W-1:0]      rdata,
  output chan_cfg_t [NCH-1:0]   cfg,
  output logic                  dup
);
  logic [AW-1:0] sel;
  assign sel = AW'(NCH - 1) - addr;

  // setup bytes are left without reset: contents are undefined until written
  for (genvar g = 0; g < NCH; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (we && sel == AW'(g)) cfg[g] <= unpack_byte(wdata);
    end
  end

  assign rdata = pack_byte(cfg[sel]);

  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      for (int j = i + 1; j < NCH; j++) begin
        if (cfg[i].level == cfg[j].level) dup = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick
  import dma_arb_pkg::*;
#(
  parameter int NCH = 4,
  localparam int AW = $clog2(NCH)
) (
  input  chan_cfg_t [NCH-1:0] cfg,
  input  logic [NCH-1:0]      req,
  input  logic [AW-1:0]       act_ch,
  input  logic [AW-1:0]       ptr,
  output logic                fx_hit,
  output logic [AW-1:0]       fx_ch,
  output logic                rr_hit,
  output logic [AW-1:0]       rr_ch,
  output logic                pe_hit,
  output logic [AW-1:0]       pe_ch
);
  logic [LVL_W-1:0] fx_best, pe_best, act_lvl;
  logic [AW-1:0]    cand;
  logic             pe_raw;

  // fixed: largest level among requesters, lowest index on a tie
  always_comb begin
    fx_hit  = 1'b0;
    fx_ch   = '0;
    fx_best = '0;
    for (int i = 0; i < NCH; i++) begin
      if (req[i] && (!fx_hit || cfg[i].level > fx_best)) begin
        fx_hit  = 1'b1;
        fx_ch   = AW'(i);
        fx_best = cfg[i].level;
      end
    end
  end

  // rotating: first requester after the pointer, with wrap-around
  always_comb begin
    rr_hit = 1'b0;
    rr_ch  = '0;
    cand   = '0;
    for (int k = 1; k <= NCH; k++) begin
      cand = AW'((int'(ptr) + k) % NCH);
      if (!rr_hit && req[cand]) begin
        rr_hit = 1'b1;
        rr_ch  = cand;
      end
    end
  end

  // takeover: strongest unbarred requester above the active level
  always_comb begin
    act_lvl = cfg[act_ch].level;
    pe_raw  = 1'b0;
    pe_ch   = '0;
    pe_best = '0;
    for (int i = 0; i < NCH; i++) begin
      if (req[i] && AW'(i) != act_ch && !cfg[i].no_pre &&
          cfg[i].level > act_lvl && (!pe_raw || cfg[i].level > pe_best)) begin
        pe_raw  = 1'b1;
        pe_ch   = AW'(i);
        pe_best = cfg[i].level;
      end
    end
    pe_hit = pe_raw && cfg[act_ch].susp_ok;
  end
endmodule

// File: rtl/dma_arb_ctrl.sv
module dma_arb_ctrl
  import dma_arb_pkg::*;
#(
  parameter int NCH = 4,
  localparam int AW = $clog2(NCH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rr_mode,
  input  logic                cfg_err,
  input  logic                done,
  input  chan_cfg_t [NCH-1:0] cfg,
  input  logic                fx_hit,
  input  logic [AW-1:0]       fx_ch,
  input  logic                rr_hit,
  input  logic [AW-1:0]       rr_ch,
  input  logic                pe_hit,
  input  logic [AW-1:0]       pe_ch,
  output logic                active,
  output logic [AW-1:0]       act_ch,
  output logic [AW-1:0]       ptr,
  output logic                preempt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      act_ch  <= '0;
      ptr     <= AW'(NCH - 1);
      preempt <= 1'b0;
    end else begin
      preempt <= 1'b0;
      if (cfg_err) begin
        active <= 1'b0;
      end else if (active) begin
        if (done) begin
          active <= 1'b0;
        end else if (!rr_mode && pe_hit) begin
          act_ch  <= pe_ch;
          ptr     <= pe_ch;
          preempt <= 1'b1;
        end
      end else if (rr_mode && rr_hit) begin
        active <= 1'b1;
        act_ch <= rr_ch;
        ptr    <= rr_ch;
      end else if (!rr_mode && fx_hit) begin
        active <= 1'b1;
        act_ch <= fx_ch;
        ptr    <= fx_ch;
      end
    end
  end

  logic [NCH-1:0] nope_vec, nope_prev;
  always_comb begin
    for (int i = 0; i < NCH; i++) nope_vec[i] = cfg[i].no_pre;
  end
  always_ff @(posedge clk) nope_prev <= nope_vec;

  AST_ERR_BLOCKS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> !active); // R4
  AST_LOCKED_KEEPS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !done && !cfg_err && !cfg[act_ch].susp_ok) |=> (active && act_ch == $past(act_ch))); // R5
  AST_BARRED_NEVER_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    preempt |-> !nope_prev[act_ch]); // R6
  AST_PREEMPT_MOVES_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    preempt |-> (active && act_ch != $past(act_ch))); // R7
  AST_ROTATE_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    preempt |-> !$past(rr_mode)); // R9
  AST_GRANT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(active) && active && act_ch != $past(act_ch)) |-> preempt); // R11
endmodule

// File: rtl/dma_chan_arb.sv
module dma_chan_arb
  import dma_arb_pkg::*;
#(
  parameter int NCH = 4,
  localparam int AW = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             rr_mode,
  input  logic [NCH-1:0]   req_in,
  input  logic             chan_done,
  output logic             grant_valid,
  output logic [AW-1:0]    grant_ch,
  output logic             preempt,
  output logic             cfg_err,
  output logic [NCH-1:0]   req_status
);
  chan_cfg_t [NCH-1:0] cfg;
  logic                dup;
  logic [NCH-1:0]      req_q;
  logic                fx_hit, rr_hit, pe_hit;
  logic [AW-1:0]       fx_ch, rr_ch, pe_ch, ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_in;
  end

  assign req_status = req_q;
  assign cfg_err    = dup && !rr_mode;

  dma_arb_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .cfg(cfg), .dup(dup)
  );

  dma_arb_pick #(.NCH(NCH)) u_pick (
    .cfg(cfg), .req(req_q), .act_ch(grant_ch), .ptr(ptr),
    .fx_hit(fx_hit), .fx_ch(fx_ch), .rr_hit(rr_hit), .rr_ch(rr_ch),
    .pe_hit(pe_hit), .pe_ch(pe_ch)
  );

  dma_arb_ctrl #(.NCH(NCH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rr_mode(rr_mode), .cfg_err(cfg_err),
    .done(chan_done), .cfg(cfg),
    .fx_hit(fx_hit), .fx_ch(fx_ch), .rr_hit(rr_hit), .rr_ch(rr_ch),
    .pe_hit(pe_hit), .pe_ch(pe_ch),
    .active(grant_valid), .act_ch(grant_ch), .ptr(ptr), .preempt(preempt)
  );

  AST_STATUS_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_status == $past(req_in)); // R2
  AST_ROTATE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    rr_mode |-> !cfg_err); // R10
endmodule

// File: tb/sim_dma_chan_arb.sv
module sim_dma_chan_arb;
  localparam int CLK_T = 10;
  localparam int F_GV = 0, F_GC = 1, F_PE = 2, F_ERR = 3, F_ST = 4, F_RD = 5;

  typedef struct {
    int    cyc;
    int    fld;
    int    val;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       rr_mode = 1'b0;
  logic [3:0] req_in = '0;
  logic       chan_done = 1'b0;
  logic       grant_valid, preempt, cfg_err;
  logic [1:0] grant_ch;
  logic [3:0] req_status;

  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   finished = 1'b0;
  exp_t exp_q[$];

  always #(CLK_T/2) clk = ~clk;

  dma_chan_arb u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rr_mode(rr_mode),
    .req_in(req_in), .chan_done(chan_done), .grant_valid(grant_valid),
    .grant_ch(grant_ch), .preempt(preempt), .cfg_err(cfg_err),
    .req_status(req_status)
  );

  function automatic int observe(int f);
    case (f)
      F_GV:    return int'(grant_valid);
      F_GC:    return int'(grant_ch);
      F_PE:    return int'(preempt);
      F_ERR:   return int'(cfg_err);
      F_ST:    return int'(req_status);
      default: return int'(cfg_rdata);
    endcase
  endfunction

  // monitor: pops items due in this cycle and compares
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #(CLK_T/4);
      for (int i = exp_q.size() - 1; i >= 0; i--) begin
        if (exp_q[i].cyc == cyc) begin
          checks++;
          if (observe(exp_q[i].fld) != exp_q[i].val) begin
            errors++;
            $display("FAIL %s field=%0d actual=%0d expected=%0d cycle=%0d",
                     exp_q[i].tag, exp_q[i].fld, observe(exp_q[i].fld), exp_q[i].val, cyc);
          end
          exp_q.delete(i);
        end
      end
    end
  end

  task automatic expect_at(int k, int f, int v, string tag);
    exp_t e;
    e.cyc = cyc + k;
    e.fld = f;
    e.val = v;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic finish_chan(logic [3:0] keep, int nxt, string tag);
    req_in = keep; chan_done = 1'b1;
    expect_at(1, F_GV, 0, "R11");
    if (nxt >= 0) begin
      expect_at(2, F_GV, 1, tag);
      expect_at(2, F_GC, nxt, tag);
      expect_at(2, F_PE, 0, tag);
    end else begin
      expect_at(2, F_GV, 0, tag);
    end
    tick(1);
    chan_done = 1'b0;
    tick(2);
  endtask

  initial begin
    tick(3);
    expect_at(1, F_GV, 0, "R11");
    expect_at(1, F_PE, 0, "R7");
    expect_at(1, F_ST, 0, "R2");
    rst_n = 1'b1;
    tick(2);
    // ch3 lvl3 susp barred, ch2 lvl1 susp, ch1 lvl2, ch0 lvl0 susp
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'h81);
    wr(2'd2, 8'h02);
    wr(2'd3, 8'h80);
    cfg_addr = 2'd0; expect_at(1, F_RD, 8'hC3, "R1"); tick(1);
    cfg_addr = 2'd3; expect_at(1, F_RD, 8'h80, "R1"); tick(1);
    cfg_addr = 2'd1; expect_at(1, F_RD, 8'h81, "R1");
    expect_at(1, F_ERR, 0, "R4"); tick(1);
    // R3: ch0 and ch2 request, ch2 has the larger level
    req_in = 4'b0101;
    expect_at(1, F_ST, 5, "R2");
    expect_at(2, F_GV, 1, "R3");
    expect_at(2, F_GC, 2, "R3");
    tick(3);
    finish_chan(4'b0001, 0, "R3");
    // R6: barred ch3 cannot take over ch0
    req_in = 4'b1001;
    expect_at(1, F_ST, 9, "R2");
    expect_at(2, F_PE, 0, "R6");
    expect_at(3, F_PE, 0, "R6");
    expect_at(3, F_GC, 0, "R6");
    tick(3);
    // R7: ch1 takes over suspendable ch0
    req_in = 4'b0011;
    expect_at(1, F_PE, 0, "R7");
    expect_at(2, F_PE, 1, "R7");
    expect_at(2, F_GC, 1, "R7");
    expect_at(3, F_PE, 0, "R7");
    expect_at(3, F_GC, 1, "R11");
    tick(4);
    // R8: ch0 resumes after ch1 finishes
    finish_chan(4'b0001, 0, "R8");
    // R5: ch0 made non-suspendable, ch1 must wait
    wr(2'd3, 8'h00);
    req_in = 4'b0011;
    expect_at(2, F_PE, 0, "R5");
    expect_at(3, F_GC, 0, "R5");
    expect_at(4, F_GC, 0, "R5");
    expect_at(4, F_GV, 1, "R5");
    tick(4);
    finish_chan(4'b0010, 1, "R3");
    finish_chan(4'b0000, -1, "R11");
    // R4: repeated level withdraws the grant
    req_in = 4'b0001;
    expect_at(2, F_GC, 0, "R3");
    expect_at(2, F_GV, 1, "R3");
    tick(3);
    expect_at(1, F_ERR, 1, "R4");
    expect_at(2, F_GV, 0, "R4");
    expect_at(4, F_GV, 0, "R4");
    wr(2'd1, 8'h02);
    tick(3);
    req_in = 4'b1111;
    expect_at(1, F_GV, 0, "R4");
    tick(1);
    // R9/R10: rotating mode from last grant ch0
    rr_mode = 1'b1;
    expect_at(1, F_ERR, 0, "R10");
    expect_at(1, F_GV, 1, "R9");
    expect_at(1, F_GC, 1, "R9");
    tick(2);
    finish_chan(4'b1111, 2, "R9");
    finish_chan(4'b1111, 3, "R9");
    finish_chan(4'b1111, 0, "R9");
    expect_at(1, F_ERR, 0, "R10");
    tick(3);
    if (exp_q.size() != 0) begin
      errors += exp_q.size();
      $display("FAIL R11 pending=%0d expected=0", exp_q.size());
    end
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_T * 20000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL R11 watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule